// File: doc/BRIEF.md
# Register access strobe decoder

This block turns one CPU register request into select lines for a register map. The request has a valid bit, a byte address and a write-direction bit. The map holds four kinds of target:

- an array of ordinary registers;
- one register wider than the bus, which is reached one bus-width slice at a time;
- an external block that covers an address window;
- three external registers. The first is readable and writable, the second can only be read and the third can only be written.

Every target has its own strobe bit. A request that lands in an external block, or on an external register in a direction that register supports, also raises an `is_external` flag. A separate output marks a field of the wide register that spans more than one slice. The register file uses these signals to update its storage and to route a request out of the block. The decoder is purely combinational and holds no state.

The strobe vector has a fixed layout, from bit 0 upward:

- bits `[ARR_N-1:0]`: the array registers;
- the next `WIDE_W/ACC_W` bits: the wide-register slices, slice 0 first;
- one bit for the external block;
- one bit each for the external registers, in the order read/write, read-only, write-only.

Top module: `acc_strobe_dec`

## Requirements
- R1: While `req_vld` is 0, `strb`, `field_strb` and `is_external` are all 0, whatever the address or direction.
- R2: Array register i (strb bit i) is asserted for a valid request whose address equals `ARR_BASE + i*ARR_STRIDE`, and for no other address.
- R3: The wide register has `WIDE_W/ACC_W` slice strobes at strb bits `ARR_N + k`. Slice k is hit at address `WIDE_BASE + k*(ACC_W/8)`.
- R4: `field_strb` is the OR of the slice strobes from `FLD_LSB/ACC_W` up to `FLD_MSB/ACC_W` inclusive. It is 0 for every other slice.
- R5: The external-block strobe (bit `ARR_N+WIDE_W/ACC_W`) is asserted for any valid address from `BLK_BASE` to `BLK_BASE+BLK_SIZE-1` inclusive. It is 0 one byte below that range and one byte above it.
- R6: Every external-block hit sets `is_external`, for reads and for writes.
- R7: External register k sits at `XREG_BASE + k*XREG_STRIDE`, with k = 0 for read/write, 1 for read-only and 2 for write-only. Its strobe is the bit after the external-block bit, offset by k, and it is asserted on an address hit in either direction. A hit on the read/write register sets `is_external` for reads and writes.
- R8: A hit on the read-only external register sets `is_external` only when `req_wr` is 0.
- R9: A hit on the write-only external register sets `is_external` only when `req_wr` is 1.
- R10: Hits on array registers or wide-register slices never set `is_external`.
- R11: At most one strobe bit is active for any request. Addresses outside the map give an all-zero strobe vector and `is_external` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_vld | input | 1 | Request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| strb | output | ARR_N+WIDE_W/ACC_W+4 | One-hot access strobes, in the layout given above |
| field_strb | output | 1 | Strobe for the field of the wide register that spans several slices |
| is_external | output | 1 | The request targets logic outside the register file |

## Verification
The bench builds the block with these parameter values:

- a 10-bit address, which is small enough to sweep the whole 1024-byte space in both directions against a model;
- an array stride of 8 bytes, which leaves unmapped holes between array entries;
- a 128-bit wide register on a 32-bit bus, which gives four slices;
- a field from bit 40 to bit 75, which covers slices 1 and 2 but neither outer slice.

The external window is 64 bytes. Its bounds, and the addresses one byte outside them, are probed directly. The three external registers are probed in both directions.

// File: rtl/acc_dec_pkg.sv
package acc_dec_pkg;

    typedef enum logic [1:0] {
        XK_RW = 2'd0,
        XK_RO = 2'd1,
        XK_WO = 2'd2
    } xreg_kind_e;

    typedef struct packed {
        logic vld;
        logic wr;
    } req_t;

    function automatic int slice_count(input int reg_w, input int acc_w);
        return reg_w / acc_w;
    endfunction

    // True when a request in direction wr is served by an external register of kind k
    function automatic logic dir_hit(input xreg_kind_e k, input logic wr);
        case (k)
            XK_RW:   return 1'b1;
            XK_RO:   return !wr;
            XK_WO:   return wr;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/acd_array_dec.sv
module acd_array_dec #(
    parameter int ADDR_W = 10,
    parameter int N      = 4,
    parameter int BASE   = 0,
    parameter int STRIDE = 8
) (
    input  logic              vld,
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      hit
);
    for (genvar i = 0; i < N; i++) begin : g_ent
        localparam logic [ADDR_W-1:0] ENT_ADDR = ADDR_W'(BASE + i * STRIDE);
        assign hit[i] = vld && (addr == ENT_ADDR);
    end
endmodule

// File: rtl/acd_wide_dec.sv
module acd_wide_dec
    import acc_dec_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int ACC_W   = 32,
    parameter int REG_W   = 128,
    parameter int BASE    = 64,
    parameter int FLD_LSB = 40,
    parameter int FLD_MSB = 75
) (
    input  logic                                 vld,
    input  logic [ADDR_W-1:0]                    addr,
    output logic [slice_count(REG_W, ACC_W)-1:0] sub,
    output logic                                 fld
);
    localparam int NSUB   = slice_count(REG_W, ACC_W);
    localparam int SBYTES = ACC_W / 8;
    localparam int S_LO   = FLD_LSB / ACC_W;
    localparam int S_HI   = FLD_MSB / ACC_W;

    for (genvar k = 0; k < NSUB; k++) begin : g_slice
        localparam logic [ADDR_W-1:0] SL_ADDR = ADDR_W'(BASE + k * SBYTES);
        assign sub[k] = vld && (addr == SL_ADDR);
    end

    if (S_HI == S_LO) begin : g_fld_one
        assign fld = sub[S_LO];
    end else begin : g_fld_many
        assign fld = |sub[S_HI:S_LO];
    end
endmodule

// File: rtl/acd_ext_dec.sv
module acd_ext_dec
    import acc_dec_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int BLK_BASE    = 256,
    parameter int BLK_SIZE    = 64,
    parameter int XREG_BASE   = 128,
    parameter int XREG_STRIDE = 4
) (
    input  req_t              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              blk,
    output logic [2:0]        xreg,
    output logic              ext
);
    localparam logic [ADDR_W-1:0] BLK_LO = ADDR_W'(BLK_BASE);
    localparam logic [ADDR_W-1:0] BLK_HI = ADDR_W'(BLK_BASE + BLK_SIZE - 1);

    logic [2:0] xflag;

    assign blk = req.vld && (addr >= BLK_LO) && (addr <= BLK_HI);

    for (genvar k = 0; k < 3; k++) begin : g_xreg
        localparam logic [ADDR_W-1:0] XA   = ADDR_W'(XREG_BASE + k * XREG_STRIDE);
        localparam xreg_kind_e        KIND = xreg_kind_e'(k);
        assign xreg[k]  = req.vld && (addr == XA);
        assign xflag[k] = xreg[k] && dir_hit(KIND, req.wr);
    end

    assign ext = blk || (|xflag);
endmodule

// File: rtl/acc_strobe_dec.sv
module acc_strobe_dec
    import acc_dec_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int ACC_W       = 32,
    parameter int ARR_N       = 4,
    parameter int ARR_BASE    = 0,
    parameter int ARR_STRIDE  = 8,
    parameter int WIDE_W      = 128,
    parameter int WIDE_BASE   = 64,
    parameter int FLD_LSB     = 40,
    parameter int FLD_MSB     = 75,
    parameter int BLK_BASE    = 256,
    parameter int BLK_SIZE    = 64,
    parameter int XREG_BASE   = 128,
    parameter int XREG_STRIDE = 4
) (
    input  logic                            req_vld,
    input  logic                            req_wr,
    input  logic [ADDR_W-1:0]               req_addr,
    output logic [ARR_N+WIDE_W/ACC_W+4-1:0] strb,
    output logic                            field_strb,
    output logic                            is_external
);
    localparam int NSUB = slice_count(WIDE_W, ACC_W);

    req_t             req;
    logic [ARR_N-1:0] arr_hit;
    logic [NSUB-1:0]  sub_hit;
    logic             blk_hit;
    logic [2:0]       xreg_hit;

    assign req = '{vld: req_vld, wr: req_wr};

    acd_array_dec #(
        .ADDR_W(ADDR_W), .N(ARR_N), .BASE(ARR_BASE), .STRIDE(ARR_STRIDE)
    ) u_arr (
        .vld(req.vld), .addr(req_addr), .hit(arr_hit)
    );

    acd_wide_dec #(
        .ADDR_W(ADDR_W), .ACC_W(ACC_W), .REG_W(WIDE_W), .BASE(WIDE_BASE),
        .FLD_LSB(FLD_LSB), .FLD_MSB(FLD_MSB)
    ) u_wide (
        .vld(req.vld), .addr(req_addr), .sub(sub_hit), .fld(field_strb)
    );

    acd_ext_dec #(
        .ADDR_W(ADDR_W), .BLK_BASE(BLK_BASE), .BLK_SIZE(BLK_SIZE),
        .XREG_BASE(XREG_BASE), .XREG_STRIDE(XREG_STRIDE)
    ) u_ext (
        .req(req), .addr(req_addr), .blk(blk_hit), .xreg(xreg_hit), .ext(is_external)
    );

    assign strb = {xreg_hit, blk_hit, sub_hit, arr_hit};
endmodule

// File: rtl/acc_strobe_dec_chk.sv
module acc_strobe_dec_chk #(
    parameter int ACC_W   = 32,
    parameter int ARR_N   = 4,
    parameter int WIDE_W  = 128,
    parameter int FLD_LSB = 40,
    parameter int FLD_MSB = 75
) (
    input logic                            req_vld,
    input logic                            req_wr,
    input logic [ARR_N+WIDE_W/ACC_W+4-1:0] strb,
    input logic                            field_strb,
    input logic                            is_external
);
    localparam int NSUB = WIDE_W / ACC_W;
    localparam int BLK  = ARR_N + NSUB;
    localparam int XRW  = BLK + 1;
    localparam int XRO  = BLK + 2;
    localparam int XWO  = BLK + 3;
    localparam int F_LO = ARR_N + FLD_LSB / ACC_W;
    localparam int F_HI = ARR_N + FLD_MSB / ACC_W;

    always_comb begin
        if (!req_vld)
            assert_idle_quiet_R1: assert (strb == '0 && !field_strb && !is_external);
        assert_single_strobe_R11: assert ($onehot0(strb));
        assert_field_cover_R4: assert (field_strb == (|strb[F_HI:F_LO]));
        if (strb[BLK])
            assert_blk_flag_R6: assert (is_external);
        if (strb[XRW])
            assert_rw_flag_R7: assert (is_external);
        if (strb[XRO])
            assert_ro_dir_R8: assert (is_external == !req_wr);
        if (strb[XWO])
            assert_wo_dir_R9: assert (is_external == req_wr);
        if (|strb[BLK-1:0])
            assert_local_no_flag_R10: assert (!is_external);
    end
endmodule

bind acc_strobe_dec acc_strobe_dec_chk #(
    .ACC_W(ACC_W), .ARR_N(ARR_N), .WIDE_W(WIDE_W),
    .FLD_LSB(FLD_LSB), .FLD_MSB(FLD_MSB)
) u_chk (
    .req_vld(req_vld), .req_wr(req_wr), .strb(strb),
    .field_strb(field_strb), .is_external(is_external)
);

// File: tb/test_acc_strobe_dec.sv
module test_acc_strobe_dec;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10, ACC_W = 32, ARR_N = 4, ARR_BASE = 0, ARR_STRIDE = 8;
    localparam int WIDE_W = 128, WIDE_BASE = 64, FLD_LSB = 40, FLD_MSB = 75;
    localparam int BLK_BASE = 256, BLK_SIZE = 64, XREG_BASE = 128, XREG_STRIDE = 4;
    localparam int NSUB = WIDE_W / ACC_W;
    localparam int NS = ARR_N + NSUB + 4;
    localparam int BLK = ARR_N + NSUB;

    logic clk = 0, rst = 1;
    logic req_vld = 0, req_wr = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [NS-1:0] strb;
    logic field_strb, is_external;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_strobe_dec #(
        .ADDR_W(ADDR_W), .ACC_W(ACC_W), .ARR_N(ARR_N), .ARR_BASE(ARR_BASE),
        .ARR_STRIDE(ARR_STRIDE), .WIDE_W(WIDE_W), .WIDE_BASE(WIDE_BASE),
        .FLD_LSB(FLD_LSB), .FLD_MSB(FLD_MSB), .BLK_BASE(BLK_BASE),
        .BLK_SIZE(BLK_SIZE), .XREG_BASE(XREG_BASE), .XREG_STRIDE(XREG_STRIDE)
    ) i_acc_strobe_dec (
        .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
        .strb(strb), .field_strb(field_strb), .is_external(is_external)
    );

    function automatic logic [NS-1:0] m_strb(input int a);
        logic [NS-1:0] s = '0;
        for (int i = 0; i < ARR_N; i++) if (a == ARR_BASE + i*ARR_STRIDE) s[i] = 1'b1;
        for (int k = 0; k < NSUB; k++) if (a == WIDE_BASE + k*(ACC_W/8)) s[ARR_N+k] = 1'b1;
        if (a >= BLK_BASE && a <= BLK_BASE + BLK_SIZE - 1) s[BLK] = 1'b1;
        for (int k = 0; k < 3; k++) if (a == XREG_BASE + k*XREG_STRIDE) s[BLK+1+k] = 1'b1;
        return s;
    endfunction

    function automatic logic m_ext(input int a, input logic wr);
        logic [NS-1:0] s = m_strb(a);
        return s[BLK] || s[BLK+1] || (s[BLK+2] && !wr) || (s[BLK+3] && wr);
    endfunction

    function automatic logic m_fld(input int a);
        logic [NS-1:0] s = m_strb(a);
        logic f = 1'b0;
        for (int k = FLD_LSB/ACC_W; k <= FLD_MSB/ACC_W; k++) f |= s[ARR_N+k];
        return f;
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input int a);
        @(negedge clk);
        req_vld = v; req_wr = w; req_addr = ADDR_W'(a);
        #2;
    endtask

    task automatic t_idle;   // R1
        for (int a = 0; a < 1024; a += 4) begin
            drive(0, a[2], a);
            if (strb != 0 || field_strb || is_external)
                check("R1", {strb, field_strb, is_external}, 0, "idle outputs");
        end
        drive(0, 1, BLK_BASE + 4);
        check("R1", {strb, field_strb, is_external}, 0, "idle in ext block");
    endtask

    task automatic t_array;  // R2, R10
        for (int i = 0; i < ARR_N; i++) begin
            drive(1, i[0], ARR_BASE + i*ARR_STRIDE);
            check("R2", strb, NS'(1) << i, "array strobe");
            check("R10", is_external, 0, "array no ext");
        end
        drive(1, 0, ARR_BASE + 4);
        check("R2", strb, 0, "array hole");
    endtask

    task automatic t_wide;   // R3, R4, R10
        for (int k = 0; k < NSUB; k++) begin
            drive(1, 1, WIDE_BASE + k*4);
            check("R3", strb, NS'(1) << (ARR_N + k), "wide slice");
            check("R4", field_strb, (k == 1 || k == 2), "field strobe");
            check("R10", is_external, 0, "wide no ext");
        end
    endtask

    task automatic t_block;  // R5, R6
        drive(1, 0, BLK_BASE);
        check("R5", strb, NS'(1) << BLK, "block low bound");
        check("R6", is_external, 1, "block read flag");
        drive(1, 1, BLK_BASE + BLK_SIZE - 1);
        check("R5", strb, NS'(1) << BLK, "block high bound");
        check("R6", is_external, 1, "block write flag");
        drive(1, 0, BLK_BASE - 1);
        check("R5", strb, 0, "below block");
        drive(1, 1, BLK_BASE + BLK_SIZE);
        check("R5", {strb, is_external}, 0, "above block");
    endtask

    task automatic t_xregs;  // R7, R8, R9
        for (int w = 0; w < 2; w++) begin
            drive(1, w[0], XREG_BASE);
            check("R7", strb, NS'(1) << (BLK+1), "rw strobe");
            check("R7", is_external, 1, "rw flag");
            drive(1, w[0], XREG_BASE + XREG_STRIDE);
            check("R8", strb, NS'(1) << (BLK+2), "ro strobe");
            check("R8", is_external, (w == 0), "ro flag");
            drive(1, w[0], XREG_BASE + 2*XREG_STRIDE);
            check("R9", strb, NS'(1) << (BLK+3), "wo strobe");
            check("R9", is_external, (w == 1), "wo flag");
        end
    endtask

    task automatic t_sweep;  // R11
        for (int w = 0; w < 2; w++)
            for (int a = 0; a < 1024; a++) begin
                drive(1, w[0], a);
                check("R11", {strb, field_strb, is_external},
                      {m_strb(a), m_fld(a), m_ext(a, w[0])}, $sformatf("sweep addr %0h", a));
                check("R11", $countones(strb) <= 1, 1, "single strobe");
            end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 0;
        drive(0, 0, 0);
        check("R1", {strb, field_strb, is_external}, 0, "initial state");
        t_idle();
        t_array();
        t_wide();
        t_block();
        t_xregs();
        t_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule